// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block models a one-time-programmable AND-OR plane that is configured from a connection bitmap. Twelve dedicated inputs and ten feedback signals are expanded into true and complement lines. Each product term ANDs the lines it is connected to. The product terms are split into three sets. Most of them feed ten OR sums of unequal size. One term per output serves as an output-enable term. Two global terms serve as a preset term and a reset term. The surrounding output cells consume these terms. The output cells are not part of this block.

The bitmap is held as one word per product term, with one bit per array line. Words are written while a configure-mode input is high, and the word at the current address can be read back. A lock request issued in configure mode freezes the bitmap and hides readback until the next reset. From inputs and feedback to the outputs there are no registers.

Top module: `prog_and_or_array`

## Requirements
- R1: Array line 2k carries signal k true and line 2k+1 carries it inverted. Signals 0..11 are `ded_in[0..11]` and signals 12..21 are `fb_in[0..9]`. Bit j of a term word connects line j, so a word is 44 bits wide.
- R2: Term addresses run in this order. First come the sum terms, one contiguous group per output, output 0 first, with group sizes 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 (addresses 0..119). Next come the enable terms for outputs 0..9 at 120..129. The preset term is at 130 and the reset term at 131.
- R3: A term word with no bit set evaluates to 1.
- R4: A term word connecting both the true and the complement line of one signal evaluates to 0, so it contributes nothing to its sum.
- R5: Each term is the AND of its connected lines. Each `sum_out[i]` is the OR of its group. All outputs follow the inputs combinationally, with no clock delay.
- R6: On a clock edge with `cfg_mode` and `cfg_we` high, `cfg_wdata` is stored at `cfg_addr`. `cfg_rdata` shows the stored word at `cfg_addr` combinationally.
- R7: A write strobe while `cfg_mode` is low changes nothing.
- R8: Reset (`rst_n` low, asynchronous) clears every word and the lock. Afterwards every term, sum, enable, preset and reset output is 1.
- R9: `cfg_lock_req` sampled high while `cfg_mode` is high sets the lock. While the lock is set, the lock stays set, writes are ignored and `cfg_rdata` reads 0. Only reset clears the lock.
- R10: A write to an address of 132 or above is ignored, and reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback signals from the output cells |
| cfg_mode | input | 1 | Configure mode; enables writes and lock request |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 8 | Term address for write and readback |
| cfg_wdata | input | 44 | Connection word to store |
| cfg_lock_req | input | 1 | Request to set the lock |
| cfg_rdata | output | 44 | Readback of the word at cfg_addr |
| sum_out | output | 10 | OR sums, one per output |
| oe_term | output | 10 | Output-enable terms |
| preset_term | output | 1 | Global preset term |
| reset_term | output | 1 | Global reset term |

## Verification
The assertions check several properties on every cycle. The lock never drops without a reset, and it rises only after a request in configure mode. Readback is zero while locked, and it holds steady while configure mode is off and the address is unchanged. Every output is 1 in the first cycle after reset. The array function itself can only be shown by the bench scenarios. That covers the line numbering, the unequal group boundaries, the empty and contradictory term rules, and the blocking of writes under lock. The bench programs a pattern, then walks input vectors and compares the output bits with values worked out from the requirements.

// File: rtl/pao_pkg.sv
package pao_pkg;

   // Size of the OR group for a given output: groups grow by step toward the
   // middle of the output range and shrink symmetrically after it.
   function automatic int group_size(int idx, int n_out, int base, int step);
      int half;
      int k;
      half = n_out / 2;
      k = (idx < half) ? idx : (n_out - 1 - idx);
      return base + step * k;
   endfunction

   // First term address of a given output's OR group.
   function automatic int group_offset(int idx, int n_out, int base, int step);
      int acc;
      acc = 0;
      for (int j = 0; j < idx; j++) acc += group_size(j, n_out, base, step);
      return acc;
   endfunction

   // Number of product terms that feed OR sums.
   function automatic int sum_term_total(int n_out, int base, int step);
      return group_offset(n_out, n_out, base, step);
   endfunction

endpackage

// File: rtl/pao_line_gen.sv
module pao_line_gen #(
   parameter int N_SIG = 22
) (
   input  logic [N_SIG-1:0]   sig,
   output logic [2*N_SIG-1:0] lines
);
   for (genvar k = 0; k < N_SIG; k++) begin : g_pair
      assign lines[2*k]   = sig[k];
      assign lines[2*k+1] = ~sig[k];
   end
endmodule

// File: rtl/pao_cfg_store.sv
module pao_cfg_store #(
   parameter int N_TERMS = 132,
   parameter int N_LINES = 44,
   parameter int AW      = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_mode,
   input  logic                              cfg_we,
   input  logic [AW-1:0]                     cfg_addr,
   input  logic [N_LINES-1:0]                cfg_wdata,
   input  logic                              cfg_lock_req,
   output logic [N_TERMS-1:0][N_LINES-1:0]   conn,
   output logic [N_LINES-1:0]                cfg_rdata,
   output logic                              locked
);
   logic addr_ok;
   logic open_win;

   assign addr_ok  = (int'(cfg_addr) < N_TERMS);
   assign open_win = cfg_mode && !locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conn   <= '0;
         locked <= 1'b0;
      end else if (open_win) begin
         if (cfg_we && addr_ok) conn[cfg_addr] <= cfg_wdata;
         if (cfg_lock_req) locked <= 1'b1;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (!locked && addr_ok) cfg_rdata = conn[cfg_addr];
   end
endmodule

// File: rtl/pao_and_plane.sv
module pao_and_plane #(
   parameter int N_TERMS = 132,
   parameter int N_LINES = 44
) (
   input  logic [N_LINES-1:0]              lines,
   input  logic [N_TERMS-1:0][N_LINES-1:0] conn,
   output logic [N_TERMS-1:0]              terms
);
   // An unconnected line is forced to 1, so an empty word yields 1 and
   // a word touching both polarities of one signal yields 0.
   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      assign terms[t] = &(lines | ~conn[t]);
   end
endmodule

// File: rtl/pao_or_plane.sv
module pao_or_plane #(
   parameter int N_OUT = 10,
   parameter int BASE  = 8,
   parameter int STEP  = 2,
   parameter int N_SUM = 120
) (
   input  logic [N_SUM-1:0] sum_terms,
   output logic [N_OUT-1:0] sums
);
   for (genvar i = 0; i < N_OUT; i++) begin : g_sum
      localparam int OFF = pao_pkg::group_offset(i, N_OUT, BASE, STEP);
      localparam int CNT = pao_pkg::group_size(i, N_OUT, BASE, STEP);
      assign sums[i] = |sum_terms[OFF +: CNT];
   end
endmodule

// File: rtl/prog_and_or_array.sv
module prog_and_or_array #(
   parameter int  N_DED   = 12,
   parameter int  N_FB    = 10,
   parameter int  BASE    = 8,
   parameter int  STEP    = 2,
   localparam int N_OUT   = N_FB,
   localparam int N_SIG   = N_DED + N_FB,
   localparam int N_LINES = 2 * N_SIG,
   localparam int N_SUM   = pao_pkg::sum_term_total(N_OUT, BASE, STEP),
   localparam int N_TERMS = N_SUM + N_OUT + 2,
   localparam int AW      = $clog2(N_TERMS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_DED-1:0]   ded_in,
   input  logic [N_FB-1:0]    fb_in,
   input  logic               cfg_mode,
   input  logic               cfg_we,
   input  logic [AW-1:0]      cfg_addr,
   input  logic [N_LINES-1:0] cfg_wdata,
   input  logic               cfg_lock_req,
   output logic [N_LINES-1:0] cfg_rdata,
   output logic [N_OUT-1:0]   sum_out,
   output logic [N_OUT-1:0]   oe_term,
   output logic               preset_term,
   output logic               reset_term
);
   if (N_OUT % 2 != 0) begin : g_bad_out
      $error("prog_and_or_array: feedback count must be even");
   end
   if (BASE < 1 || STEP < 0) begin : g_bad_grp
      $error("prog_and_or_array: group sizes must be positive");
   end

   logic [N_LINES-1:0]              lines;
   logic [N_TERMS-1:0][N_LINES-1:0] conn;
   logic [N_TERMS-1:0]              terms;
   logic                            locked;

   pao_line_gen #(.N_SIG(N_SIG)) u_lines (
      .sig   ({fb_in, ded_in}),
      .lines (lines)
   );

   pao_cfg_store #(.N_TERMS(N_TERMS), .N_LINES(N_LINES), .AW(AW)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_mode     (cfg_mode),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .cfg_lock_req (cfg_lock_req),
      .conn         (conn),
      .cfg_rdata    (cfg_rdata),
      .locked       (locked)
   );

   pao_and_plane #(.N_TERMS(N_TERMS), .N_LINES(N_LINES)) u_and (
      .lines (lines),
      .conn  (conn),
      .terms (terms)
   );

   pao_or_plane #(.N_OUT(N_OUT), .BASE(BASE), .STEP(STEP), .N_SUM(N_SUM)) u_or (
      .sum_terms (terms[N_SUM-1:0]),
      .sums      (sum_out)
   );

   assign oe_term     = terms[N_SUM +: N_OUT];
   assign preset_term = terms[N_SUM + N_OUT];
   assign reset_term  = terms[N_SUM + N_OUT + 1];
endmodule

// File: rtl/prog_and_or_array_chk.sv
module prog_and_or_array_chk #(
   parameter int N_OUT   = 10,
   parameter int N_LINES = 44,
   parameter int AW      = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_mode,
   input logic               cfg_lock_req,
   input logic [AW-1:0]      cfg_addr,
   input logic [N_LINES-1:0] cfg_rdata,
   input logic               locked,
   input logic [N_OUT-1:0]   sum_out,
   input logic [N_OUT-1:0]   oe_term,
   input logic               preset_term,
   input logic               reset_term
);
   // R9: lock is sticky until reset
   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R9: lock only rises after a request made in configure mode
   assert_lock_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(cfg_mode && cfg_lock_req));

   // R9: readback hidden while locked
   assert_locked_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (cfg_rdata == '0));

   // R7: no stored word changes while configure mode is off
   assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_rdata))));

   // R8: cleared array gives all-one outputs right after reset
   assert_reset_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&sum_out && &oe_term && preset_term && reset_term));
endmodule

bind prog_and_or_array prog_and_or_array_chk #(
   .N_OUT(N_OUT), .N_LINES(N_LINES), .AW(AW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_mode     (cfg_mode),
   .cfg_lock_req (cfg_lock_req),
   .cfg_addr     (cfg_addr),
   .cfg_rdata    (cfg_rdata),
   .locked       (locked),
   .sum_out      (sum_out),
   .oe_term      (oe_term),
   .preset_term  (preset_term),
   .reset_term   (reset_term)
);

// File: tb/prog_and_or_array_bench.sv
module prog_and_or_array_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] ded_in = '0;
   logic [9:0]  fb_in = '0;
   logic        cfg_mode = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [43:0] cfg_wdata = '0;
   logic        cfg_lock_req = 1'b0;
   logic [43:0] cfg_rdata;
   logic [9:0]  sum_out;
   logic [9:0]  oe_term;
   logic        preset_term;
   logic        reset_term;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   prog_and_or_array u_prog_and_or_array (.*);

   localparam logic [43:0] CONTRA = 44'h3;   // line 0 and line 1: d0 & ~d0

   // {ded_in, fb_in, expected {s0, s4, s9, en0, pre, rst}}
   localparam logic [27:0] VEC [8] = '{
      {12'h000, 10'h000, 6'b001000},
      {12'h001, 10'h000, 6'b101000},
      {12'h003, 10'h000, 6'b001000},
      {12'h00C, 10'h000, 6'b011000},
      {12'h830, 10'h000, 6'b000101},
      {12'h010, 10'h201, 6'b011010},
      {12'h004, 10'h000, 6'b001000},
      {12'hFFF, 10'h3FF, 6'b010110}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [43:0] data);
      @(negedge clk);
      cfg_addr  = 8'(addr);
      cfg_wdata = data;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [43:0] data);
      @(negedge clk);
      cfg_addr = 8'(addr);
      #1 data = cfg_rdata;
   endtask

   task automatic apply(input logic [11:0] d, input logic [9:0] f);
      @(negedge clk);
      ded_in = d;
      fb_in  = f;
      #1;
   endtask

   function automatic logic [5:0] pick();
      return {sum_out[0], sum_out[4], sum_out[9], oe_term[0], preset_term, reset_term};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [43:0] rb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8, R3: cleared array, all outputs high
      apply(12'h5A5, 10'h2C3);
      check("R8 sums after reset", 64'(sum_out), 64'h3FF);
      check("R3 enables empty", 64'(oe_term), 64'h3FF);
      check("R8 preset/reset terms", 64'({preset_term, reset_term}), 64'h3);
      rd(0, rb);
      check("R8 word cleared", 64'(rb), 64'h0);

      // Program the array (R1 line numbering, R2 addresses)
      cfg_mode = 1'b1;
      wr(0, 44'h9);                                   // d0 & ~d1
      for (int a = 1; a <= 7; a++) wr(a, CONTRA);
      wr(44, 44'h1 << 24);                            // fb0
      wr(45, 44'h50);                                 // d2 & d3
      for (int a = 46; a <= 75; a++) wr(a, CONTRA);   // rest of out4, all of out5
      for (int a = 112; a <= 118; a++) wr(a, CONTRA);
      wr(119, 44'h1 << 23);                           // ~d11, last term of out9
      wr(120, 44'h1 << 10);                           // enable0 = d5
      wr(129, CONTRA);                                // enable9 = 0
      wr(130, 44'h1 << 42);                           // preset = fb9
      wr(131, (44'h1 << 43) | (44'h1 << 8));          // reset = ~fb9 & d4
      rd(45, rb);
      check("R6 readback", 64'(rb), 64'h50);
      rd(131, rb);
      check("R2 last address readback", 64'(rb), 64'(((44'h1 << 43) | (44'h1 << 8))));

      // R7: strobe outside configure mode
      cfg_mode = 1'b0;
      wr(0, 44'h0);
      rd(0, rb);
      check("R7 write ignored", 64'(rb), 64'h9);

      // R1, R2, R5: vector table
      for (int i = 0; i < 8; i++) begin
         apply(VEC[i][27:16], VEC[i][15:6]);
         check($sformatf("R5 vector %0d", i), 64'(pick()), 64'(VEC[i][5:0]));
      end
      check("R4 contradictory sum5", 64'(sum_out[5]), 64'h0);
      check("R4 contradictory enable9", 64'(oe_term[9]), 64'h0);
      check("R3 untouched sum1", 64'(sum_out[1]), 64'h1);

      // R10: out-of-range address
      cfg_mode = 1'b1;
      wr(200, 44'hFFF_FFFF_FFFF);
      rd(200, rb);
      check("R10 out of range reads 0", 64'(rb), 64'h0);
      apply(12'h001, 10'h000);
      check("R10 outputs unchanged", 64'(pick()), 64'b101000);

      // R9: lock
      @(negedge clk);
      cfg_lock_req = 1'b1;
      @(negedge clk);
      cfg_lock_req = 1'b0;
      rd(0, rb);
      check("R9 readback hidden", 64'(rb), 64'h0);
      wr(0, 44'h0);
      apply(12'h003, 10'h000);
      check("R9 write blocked", 64'(sum_out[0]), 64'h0);

      // R8, R9: reset clears lock and array
      cfg_mode = 1'b0;
      do_reset();
      apply(12'h003, 10'h000);
      check("R8 sums after second reset", 64'(sum_out), 64'h3FF);
      cfg_mode = 1'b1;
      wr(3, 44'h123);
      rd(3, rb);
      check("R9 lock cleared by reset", 64'(rb), 64'h123);
      cfg_mode = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule